// File: doc/BRIEF.md
# Serial Line Receiver with Framing and Break Detection

This block receives asynchronous serial frames on one input line. The line is resynchronised, then sampled at sixteen times the bit rate, with a programmable clock divider setting that rate. Each frame has a low start bit and eight data bits, least significant bit first. In address-bit mode a ninth marker bit follows the data. A high stop bit closes the frame. When a good frame ends, the byte and the marker bit are presented together with a one-cycle valid strobe.

A stop bit that is sampled low raises a sticky framing-error flag. The receiver then watches the line. If the line stays low without a break for ten more bit periods, a sticky break flag and its interrupt request are raised, and the receiver stops assembling frames. A long low stretch that starts anywhere other than a missing stop bit can never reach the break flag. A software-reset input clears both flags. After it, the receiver waits for one full bit period of high line before it looks for a new start bit.

Top module: `uart_brk_rx`

## Requirements
- R1: During and after reset, all flags, rx_valid and rx_data are 0. The receiver waits for one bit period of high line before it accepts a start bit, so a line held low through reset produces no frame and no flag.
- R2: One bit period is (baud_div+1)*16 clock cycles. Each bit is decided by a 2-of-3 vote of the samples at oversample counts 7, 8 and 9. A frame is a low start bit, 8 data bits sent least significant bit first, and a high stop bit. A good frame updates rx_data and gives a one-cycle rx_valid pulse.
- R3: With addr_mode=1, one extra bit between data bit 7 and the stop bit is captured into rx_addr. With addr_mode=0, rx_addr reads 0.
- R4: A stop bit sampled low sets frame_err. That frame gives no rx_valid, and rx_data keeps its previous value.
- R5: After a missing stop bit, if the line stays low for ten more bit periods, brk_det and brk_irq become 1. They remain 1 until soft_rst.
- R6: A frame of all-zero data with a 0 marker bit and a high stop bit is received normally with no flag. A low stretch after a missing stop bit that ends before ten bit periods leaves brk_det at 0.
- R7: soft_rst clears frame_err and brk_det in the next cycle. It takes priority over a stop-bit or break event in the same cycle.
- R8: While brk_det is 1, no frame is received. After soft_rst and one bit period of high line, reception resumes.
- R9: A low pulse on the line shorter than half a bit period is ignored and produces no frame and no flag.
- R10: With a 100 MHz clock and baud_div=325, a frame sent at 19200 bit/s is received correctly.
- R11: rx_data and rx_addr change only in the cycle where rx_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Clears the flags and restarts the receiver |
| baud_div | input | 16 | Clocks per oversample tick, minus one |
| addr_mode | input | 1 | Enables the marker bit after the data |
| rx | input | 1 | Serial input line, high when idle |
| rx_data | output | 8 | Last good byte received |
| rx_addr | output | 1 | Marker bit of the last good frame |
| rx_valid | output | 1 | One-cycle strobe for a good frame |
| frame_err | output | 1 | Sticky flag for a missing stop bit |
| brk_det | output | 1 | Sticky break flag |
| brk_irq | output | 1 | Break interrupt request |

## Verification
Two events can land in the same cycle: the software reset, and the stop-bit decision that would raise the framing error (or the end of the break count). The bench provokes this by holding soft_rst high across the whole sampling window of a stop bit that is driven low. It then requires both flags to read 0 once the line is released high. Random frames, with and without the marker bit, are compared against bytes the bench serialises itself. Directed frames cover the all-zero frame, a low stretch that is too short to be a break, and a real break.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  typedef enum logic [2:0] {
    ST_WAITHI,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_ADDR,
    ST_STOP,
    ST_BRK,
    ST_HOLD
  } rx_state_e;

  // 2-of-3 vote used for every bit decision
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Divider value for a given clock and bit rate at 16x oversampling (rounded)
  function automatic int unsigned baud_div_calc(input int unsigned clk_hz,
                                                input int unsigned baud);
    return (clk_hz + 8 * baud) / (16 * baud) - 1;
  endfunction

endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // flops reset to the idle-high level so a low line at reset is not a start bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_brk_tick.sv
module uart_brk_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_brk_timer.sv
module uart_brk_timer #(
  parameter int LIMIT = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  assign done = en && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OS_RATE  = 16,
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              addr_mode,
  input  logic              rx,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              brk_det,
  output logic              brk_irq
);
  localparam int OS_W      = $clog2(OS_RATE);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int MID       = OS_RATE / 2;
  localparam int LAST      = OS_RATE - 1;
  localparam int BRK_TICKS = BRK_BITS * OS_RATE;

  rx_state_e         state;
  logic              rxs, tick;
  logic [OS_W-1:0]   os_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              s_a, s_b, abit, voted, decide, at_last;
  logic              stop_miss_ev, frame_ok_ev, brk_ev, brk_en;

  uart_brk_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx), .dout(rxs));

  uart_brk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick));

  assign brk_en = tick && (state == ST_BRK) && !rxs;

  uart_brk_timer #(.LIMIT(BRK_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_BRK), .en(brk_en), .done(brk_ev));

  // named events for the checker
  assign voted        = maj3(s_a, s_b, rxs);
  assign decide       = tick && (os_cnt == OS_W'(MID + 1));
  assign at_last      = tick && (os_cnt == OS_W'(LAST));
  assign stop_miss_ev = (state == ST_STOP) && decide && !voted;
  assign frame_ok_ev  = (state == ST_STOP) && decide && voted;
  assign brk_irq      = brk_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAITHI;
      os_cnt    <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      abit      <= 1'b0;
      rx_data   <= '0;
      rx_addr   <= 1'b0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      brk_det   <= 1'b0;
    end else if (soft_rst) begin
      state     <= ST_WAITHI;
      os_cnt    <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      brk_det   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (stop_miss_ev) frame_err <= 1'b1;
      if (brk_ev)       brk_det   <= 1'b1;
      if (tick) begin
        if (os_cnt == OS_W'(MID - 1)) s_a <= rxs;
        if (os_cnt == OS_W'(MID))     s_b <= rxs;
      end
      if (tick) begin
        unique case (state)
          ST_WAITHI: begin
            if (!rxs) os_cnt <= '0;
            else if (os_cnt == OS_W'(LAST)) begin
              state  <= ST_IDLE;
              os_cnt <= '0;
            end else os_cnt <= os_cnt + 1'b1;
          end
          ST_IDLE: begin
            if (!rxs) begin
              state  <= ST_START;
              os_cnt <= '0;
            end
          end
          ST_START: begin
            os_cnt <= os_cnt + 1'b1;
            if (decide && voted) begin
              state  <= ST_IDLE;
              os_cnt <= '0;
            end else if (at_last) begin
              state   <= ST_DATA;
              bit_idx <= '0;
              os_cnt  <= '0;
            end
          end
          ST_DATA: begin
            os_cnt <= os_cnt + 1'b1;
            if (decide) shreg <= {voted, shreg[DATA_W-1:1]};
            if (at_last) begin
              os_cnt  <= '0;
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == BIT_W'(DATA_W - 1))
                state <= addr_mode ? ST_ADDR : ST_STOP;
            end
          end
          ST_ADDR: begin
            os_cnt <= os_cnt + 1'b1;
            if (decide) abit <= voted;
            if (at_last) begin
              os_cnt <= '0;
              state  <= ST_STOP;
            end
          end
          ST_STOP: begin
            os_cnt <= os_cnt + 1'b1;
            if (frame_ok_ev) begin
              rx_data  <= shreg;
              rx_addr  <= addr_mode & abit;
              rx_valid <= 1'b1;
              state    <= ST_IDLE;
              os_cnt   <= '0;
            end else if (stop_miss_ev) begin
              state  <= ST_BRK;
              os_cnt <= '0;
            end
          end
          ST_BRK: begin
            if (rxs)         state <= ST_IDLE;
            else if (brk_ev) state <= ST_HOLD;
          end
          ST_HOLD: state <= ST_HOLD;
          default: state <= ST_WAITHI;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_addr,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              brk_det,
  input logic              stop_miss_ev
);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_stop_miss_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_miss_ev && !soft_rst) |=> (frame_err && !rx_valid));

  assert_brk_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && !soft_rst) |=> brk_det);

  assert_brk_needs_ferr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> frame_err);

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!frame_err && !brk_det && !rx_valid));

  assert_no_frame_in_brk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> !rx_valid);

  assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_addr)));
endmodule

bind uart_brk_rx uart_brk_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_data(rx_data),
  .rx_addr(rx_addr), .rx_valid(rx_valid), .frame_err(frame_err),
  .brk_det(brk_det), .stop_miss_ev(stop_miss_ev));

// File: tb/tb_uart_brk_rx.sv
module tb_uart_brk_rx;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, addr_mode = 1'b0, rx = 1'b0;
  logic [15:0] baud_div = 16'd3;
  logic [7:0]  rx_data;
  logic        rx_addr, rx_valid, frame_err, brk_det, brk_irq;

  int checks = 0, errors = 0, vcnt = 0, bitp = 64;
  logic [7:0] last_data = '0;
  logic       last_addr = 1'b0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  uart_brk_rx dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_div(baud_div),
    .addr_mode(addr_mode), .rx(rx), .rx_data(rx_data), .rx_addr(rx_addr),
    .rx_valid(rx_valid), .frame_err(frame_err), .brk_det(brk_det), .brk_irq(brk_irq));

  always @(negedge clk) if (rst_n && rx_valid) begin
    vcnt++;
    last_data = rx_data;
    last_addr = rx_addr;
  end

  function automatic int bit_clocks(input int clk_hz, input int baud);
    // nearest divider for 16x, expressed as clocks per bit
    int d = (2 * clk_hz / (16 * baud) + 1) / 2;
    return d * 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int bits);
    @(negedge clk) rx = lvl;
    repeat (bits * bitp) @(negedge clk);
  endtask

  task automatic send_head(input logic [7:0] d, input bit with_addr, input logic ab);
    hold(1'b0, 1);
    for (int i = 0; i < 8; i++) hold(d[i], 1);
    if (with_addr) hold(ab, 1);
  endtask

  task automatic send(input logic [7:0] d, input bit with_addr, input logic ab, input logic stopv);
    send_head(d, with_addr, ab);
    hold(stopv, 1);
  endtask

  task automatic pulse_soft;
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] d;
    logic ab, am;
    void'($urandom(32'h5eed_1234));
    // R1: reset with line low
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (3 * bitp) @(negedge clk);
    check(vcnt == 0 && !frame_err && !brk_det && !rx_valid && rx_data == 0, "R1", {frame_err, brk_det, vcnt[7:0]}, 0);
    hold(1'b1, 2);
    check(vcnt == 0 && !frame_err && !brk_det, "R1 release", vcnt, 0);

    // R2: basic frame, LSB first
    send(8'h35, 0, 0, 1); hold(1'b1, 1);
    check(vcnt == 1 && last_data == 8'h35, "R2", last_data, 8'h35);
    check(!frame_err && !brk_det, "R2 flags", {frame_err, brk_det}, 0);

    // R6: all-zero frame with zero marker bit is legal
    addr_mode = 1'b1;
    send(8'h00, 1, 0, 1); hold(1'b1, 1);
    check(vcnt == 2 && last_data == 0 && last_addr == 0 && !frame_err && !brk_det, "R6 zero frame",
          {frame_err, brk_det, last_data}, 0);

    // R3: marker bit captured
    send(8'hC3, 1, 1, 1); hold(1'b1, 1);
    check(last_data == 8'hC3 && last_addr == 1'b1, "R3", {last_addr, last_data}, 9'h1C3);

    // R2/R3/R11: random frames
    for (int k = 0; k < 24; k++) begin
      am = 1'($urandom % 2);
      ab = 1'($urandom % 2);
      d  = 8'($urandom);
      addr_mode = am;
      base = vcnt;
      send(d, am, ab, 1); hold(1'b1, 1);
      check(vcnt == base + 1 && last_data == d && last_addr == (am & ab) && rx_data == d,
            am ? "R3 random" : "R2 random", {last_addr, last_data}, {am & ab, d});
    end
    addr_mode = 1'b0;

    // R9: short glitch ignored
    base = vcnt;
    @(negedge clk) rx = 1'b0;
    repeat (bitp / 4) @(negedge clk);
    hold(1'b1, 2);
    check(vcnt == base && !frame_err && !brk_det, "R9", vcnt - base, 0);

    // R4/R6: missing stop, short low stretch, no break
    base = vcnt;
    send(8'h5A, 0, 0, 0);
    hold(1'b0, 6);
    hold(1'b1, 2);
    check(frame_err == 1'b1, "R4 frame_err", frame_err, 1);
    check(vcnt == base && rx_data == last_data, "R4 no data", vcnt - base, 0);
    check(!brk_det && !brk_irq, "R6 short low", {brk_det, brk_irq}, 0);

    // R7: soft reset clears
    pulse_soft; hold(1'b1, 2);
    check(!frame_err && !brk_det, "R7 clear", {frame_err, brk_det}, 0);
    send(8'h9E, 0, 0, 1); hold(1'b1, 1);
    check(last_data == 8'h9E, "R7 resume", last_data, 8'h9E);

    // R5: real break
    send(8'h00, 0, 0, 0);
    hold(1'b0, 11);
    check(brk_det && brk_irq && frame_err, "R5", {brk_det, brk_irq, frame_err}, 7);

    // R8: no frames while break held
    base = vcnt;
    hold(1'b1, 2);
    send(8'h77, 0, 0, 1); hold(1'b1, 1);
    check(vcnt == base && brk_det, "R8 blocked", vcnt - base, 0);
    pulse_soft; hold(1'b1, 2);
    send(8'h77, 0, 0, 1); hold(1'b1, 1);
    check(vcnt == base + 1 && last_data == 8'h77 && !brk_det, "R8 resume", last_data, 8'h77);

    // R7: soft reset held across a missing-stop decision
    send_head(8'h11, 0, 0);
    @(negedge clk) begin rx = 1'b0; soft_rst = 1'b1; end
    repeat (2 * bitp) @(negedge clk);
    soft_rst = 1'b0;
    hold(1'b1, 2);
    check(!frame_err && !brk_det, "R7 same cycle", {frame_err, brk_det}, 0);

    // R10: 19200 bit/s at 100 MHz
    baud_div = 16'd325;
    bitp = bit_clocks(100_000_000, 19200);
    hold(1'b1, 1);
    base = vcnt;
    send(8'hA5, 0, 0, 1); hold(1'b1, 1);
    check(vcnt == base + 1 && last_data == 8'hA5, "R10", last_data, 8'hA5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule